// File: doc/BRIEF.md
# Receive Polarity Detect and Correct

This block watches the decoded receive events of one twisted-pair port and decides whether the wire pair is crossed. The receive front end gives it one-cycle strobes for four kinds of event: a link pulse with the expected sense, a link pulse with the opposite sense, a frame ending in a normal start-of-idle, and a frame ending in an inverted start-of-idle. Each evidence stream has its own run threshold, and the two streams are tracked separately. When either run reaches its threshold, the block toggles `invert_o`. The front end uses `invert_o` to flip the received signal, so after a toggle it reports events relative to the corrected polarity.

The block also restores the default polarity. While `link_fail_i` is high, it counts millisecond ticks, and any received activity restarts that count. When the count reaches a fixed limit inside the 96–128 ms window (112 ms by default), `invert_o` returns to 0. When link testing is turned off, link pulses are ignored completely and only frame endings count as evidence or as activity. `pol_evt_o` is a one-cycle status pulse that marks each change of `invert_o`.

Top module: `pol_fix`

## Requirements
- R1: While `rst_ni` is low, `invert_o` and `pol_evt_o` are 0, and both evidence runs and the restore timer are empty.
- R2: With `link_test_en_i`=1, the 16th consecutive `lp_inv_i` strobe toggles `invert_o` at the same clock edge. Fifteen such strobes leave it unchanged.
- R3: An `lp_ok_i` strobe with `link_test_en_i`=1 empties the wrong-sense pulse run. If `lp_ok_i` and `lp_inv_i` arrive in the same cycle, the clear wins.
- R4: The 4th consecutive `eof_inv_i` strobe toggles `invert_o`. An `eof_ok_i` strobe empties the inverted-frame run.
- R5: With `link_test_en_i`=0, `lp_ok_i` and `lp_inv_i` have no effect. They neither count, clear the pulse run, nor restart the restore timer.
- R6: Both runs are emptied in the cycle `invert_o` changes, so a partial run collected before a change does not count afterwards. Both runs saturate at their thresholds.
- R7: While `link_fail_i`=1, each `tick_ms_i` with no activity advances the restore timer. The 112th such tick sets `invert_o` to 0. Activity, or `link_fail_i`=0, resets the timer.
- R8: `pol_evt_o` is 1 for exactly the cycle after each clock edge at which `invert_o` changed value, and is 0 otherwise.
- R9: A declaration while `invert_o`=1 toggles it back to 0.
- R10: The two runs are independent. Frame strobes do not break a link-pulse run, and link-pulse strobes do not break a frame run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle strobe, once per millisecond |
| link_test_en_i | input | 1 | 1 = link pulses are used as evidence and activity |
| link_fail_i | input | 1 | Port is in link fail state |
| lp_ok_i | input | 1 | Link pulse seen with expected sense |
| lp_inv_i | input | 1 | Link pulse seen with opposite sense |
| eof_ok_i | input | 1 | Frame end with normal start-of-idle |
| eof_inv_i | input | 1 | Frame end with inverted start-of-idle |
| invert_o | output | 1 | 1 = flip received signal |
| pol_evt_o | output | 1 | Pulse marking a change of `invert_o` |

## Verification
The in-line properties check the following on every cycle:
- every change of `invert_o` is matched by a `pol_evt_o` pulse and has a cause (a run hit or a timer expiry);
- a run is empty after a clear or a polarity change;
- the pulse run is frozen while link testing is off;
- the timer is empty outside link fail or after activity;
- an expiry leaves `invert_o` at 0.

Only the bench scenarios show the exact thresholds and the exact tick count of the restore window, since the properties never count to them. The same holds for the independence of the two runs and for the toggle back from the inverted state.

// File: rtl/pol_fix_pkg.sv
package pol_fix_pkg;

  typedef enum logic [1:0] {
    POL_HOLD    = 2'd0,
    POL_TOGGLE  = 2'd1,
    POL_DEFAULT = 2'd2
  } pol_act_e;

  // a declaration outranks a restore; the two cannot coincide since a hit implies activity
  function automatic pol_act_e pol_decide(input logic pulse_hit, input logic frame_hit,
                                          input logic expire);
    if (pulse_hit || frame_hit) return POL_TOGGLE;
    if (expire)                 return POL_DEFAULT;
    return POL_HOLD;
  endfunction

endpackage

// File: rtl/pol_run_cnt.sv
module pol_run_cnt #(
  parameter int TH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         break_i,
  input  logic                         step_i,
  output logic                         hit_o,
  output logic [$clog2(TH+1)-1:0]      cnt_o
);
  localparam int CW = $clog2(TH + 1);
  localparam logic [CW-1:0] LAST = CW'(TH - 1);
  localparam logic [CW-1:0] TOP  = CW'(TH);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (flush_i || break_i)  cnt_d = '0;
    else if (step_i)         cnt_d = (cnt_q == TOP) ? TOP : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assign hit_o = step_i && !break_i && (cnt_q >= LAST);
  assign cnt_o = cnt_q;

  p_break_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_i |=> cnt_q == '0);
  p_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_q == '0);
  p_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP);

endmodule

// File: rtl/pol_restore_tmr.sv
module pol_restore_tmr #(
  parameter int LIMIT_MS = 112
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_i,
  input  logic tick_i,
  input  logic act_i,
  output logic expire_o
);
  localparam int TW = $clog2(LIMIT_MS + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT_MS - 1);

  logic [TW-1:0] cnt_q;
  logic          idle;

  assign idle     = fail_i && !act_i;
  assign expire_o = idle && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)            cnt_q <= '0;
    else if (!idle)         cnt_q <= '0;
    else if (expire_o)      cnt_q <= '0;
    else if (tick_i)        cnt_q <= cnt_q + 1'b1;

  p_idle_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fail_i || act_i) |=> cnt_q == '0);
  p_no_tick_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_i && !act_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pol_fix.sv
module pol_fix
  import pol_fix_pkg::*;
#(
  parameter int LP_RUN     = 16,
  parameter int FR_RUN     = 4,
  parameter int RESTORE_MS = 112
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_ms_i,
  input  logic link_test_en_i,
  input  logic link_fail_i,
  input  logic lp_ok_i,
  input  logic lp_inv_i,
  input  logic eof_ok_i,
  input  logic eof_inv_i,
  output logic invert_o,
  output logic pol_evt_o
);
  localparam int LPW = $clog2(LP_RUN + 1);
  localparam int FRW = $clog2(FR_RUN + 1);

  logic           lp_step, lp_break, lp_hit;
  logic           fr_hit, tmr_expire, activity;
  logic           inv_q, inv_d, inv_chg, evt_q;
  logic [LPW-1:0] lp_cnt;
  logic [FRW-1:0] fr_cnt;
  pol_act_e       act;

  // link pulses count only when link testing is on
  assign lp_step  = link_test_en_i && lp_inv_i;
  assign lp_break = link_test_en_i && lp_ok_i;
  assign activity = (link_test_en_i && (lp_ok_i || lp_inv_i)) || eof_ok_i || eof_inv_i;

  pol_run_cnt #(.TH(LP_RUN)) u_lp_run (
    .clk_i, .rst_ni, .flush_i(inv_chg), .break_i(lp_break), .step_i(lp_step),
    .hit_o(lp_hit), .cnt_o(lp_cnt)
  );

  pol_run_cnt #(.TH(FR_RUN)) u_fr_run (
    .clk_i, .rst_ni, .flush_i(inv_chg), .break_i(eof_ok_i), .step_i(eof_inv_i),
    .hit_o(fr_hit), .cnt_o(fr_cnt)
  );

  pol_restore_tmr #(.LIMIT_MS(RESTORE_MS)) u_tmr (
    .clk_i, .rst_ni, .fail_i(link_fail_i), .tick_i(tick_ms_i), .act_i(activity),
    .expire_o(tmr_expire)
  );

  always_comb begin
    act = pol_decide(lp_hit, fr_hit, tmr_expire);
    unique case (act)
      POL_TOGGLE:  inv_d = !inv_q;
      POL_DEFAULT: inv_d = 1'b0;
      default:     inv_d = inv_q;
    endcase
  end

  assign inv_chg = inv_d != inv_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      inv_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      inv_q <= inv_d;
      evt_q <= inv_chg;
    end

  assign invert_o  = inv_q;
  assign pol_evt_o = evt_q;

  p_evt_on_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invert_o != $past(invert_o)) |-> pol_evt_o);
  p_evt_only_change_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pol_evt_o |-> (invert_o != $past(invert_o)));
  p_change_has_cause_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invert_o != $past(invert_o)) |-> $past(lp_hit || fr_hit || tmr_expire));
  p_restore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_expire |=> !invert_o);
  p_ltd_ignore_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!link_test_en_i && !inv_chg) |=> $stable(lp_cnt));
  p_frame_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_chg |=> (fr_cnt == '0 && lp_cnt == '0));

endmodule

// File: tb/pol_fix_bench.sv
module pol_fix_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_ni, tick, en, fail, lpo, lpi, eo, ei;
  logic inv, evt;

  pol_fix u_pol_fix (
    .clk_i(clk), .rst_ni(rst_ni), .tick_ms_i(tick), .link_test_en_i(en),
    .link_fail_i(fail), .lp_ok_i(lpo), .lp_inv_i(lpi), .eof_ok_i(eo),
    .eof_inv_i(ei), .invert_o(inv), .pol_evt_o(evt)
  );

  int n_chk = 0, n_fail = 0;
  string req = "R1";
  bit done = 0;
  int m_lp = 0, m_fr = 0, m_tmr = 0;
  bit m_inv = 0, m_evt = 0;

  task automatic check(bit ok, string r, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic model(bit lo, bit li, bit fo, bit fi, bit tk);
    bit a, lh, fh, ex, ni;
    a = (en && (lo || li)) || fo || fi;
    lh = 0; fh = 0;
    if (en) begin
      if (lo) m_lp = 0;
      else if (li) begin
        if (m_lp >= 15) lh = 1;
        m_lp = (m_lp < 16) ? m_lp + 1 : 16;
      end
    end
    if (fo) m_fr = 0;
    else if (fi) begin
      if (m_fr >= 3) fh = 1;
      m_fr = (m_fr < 4) ? m_fr + 1 : 4;
    end
    ex = fail && tk && !a && (m_tmr == 111);
    if (!fail || a) m_tmr = 0;
    else if (tk) m_tmr = ex ? 0 : m_tmr + 1;
    ni = m_inv;
    if (lh || fh) ni = !m_inv;
    else if (ex) ni = 0;
    m_evt = (ni != m_inv);
    if (m_evt) begin m_lp = 0; m_fr = 0; end
    m_inv = ni;
  endtask

  task automatic step(bit lo, bit li, bit fo, bit fi, bit tk);
    @(negedge clk);
    lpo = lo; lpi = li; eo = fo; ei = fi; tick = tk;
    @(posedge clk);
    model(lo, li, fo, fi, tk);
    #1;
    check(inv == m_inv, req, "invert_o vs model", int'(inv), int'(m_inv));
    check(evt == m_evt, req, "pol_evt_o vs model", int'(evt), int'(m_evt));
  endtask

  task automatic rep(int n, bit lo, bit li, bit fo, bit fi, bit tk);
    for (int i = 0; i < n; i++) step(lo, li, fo, fi, tk);
  endtask

  task automatic expect_inv(string r, bit e);
    check(inv == e, r, "invert_o scenario", int'(inv), int'(e));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 0; tick = 0; en = 1; fail = 0; lpo = 0; lpi = 0; eo = 0; ei = 0;
    repeat (3) @(posedge clk);
    #1;
    check(inv == 0, "R1", "invert_o in reset", int'(inv), 0);
    check(evt == 0, "R1", "pol_evt_o in reset", int'(evt), 0);
    @(negedge clk) rst_ni = 1;

    // R2: 15 wrong pulses hold, 16th toggles; R8 pulse
    req = "R2";
    rep(15, 0, 1, 0, 0, 0); expect_inv("R2", 0);
    step(0, 1, 0, 0, 0);    expect_inv("R2", 1);
    check(evt == 1, "R8", "pol_evt_o on toggle", int'(evt), 1);
    step(0, 0, 0, 0, 0);
    check(evt == 0, "R8", "pol_evt_o one cycle", int'(evt), 0);

    // R3 break, R9 toggle back
    req = "R3";
    rep(10, 0, 1, 0, 0, 0); step(1, 1, 0, 0, 0);
    rep(15, 0, 1, 0, 0, 0); expect_inv("R3", 1);
    req = "R9";
    step(0, 1, 0, 0, 0);    expect_inv("R9", 0);

    // R4 frame run
    req = "R4";
    rep(3, 0, 0, 0, 1, 0); step(0, 0, 1, 0, 0);
    rep(3, 0, 0, 0, 1, 0); expect_inv("R4", 0);
    step(0, 0, 0, 1, 0);   expect_inv("R4", 1);

    // R5 link test off: pulses ignored
    req = "R5";
    en = 0;
    rep(20, 0, 1, 0, 0, 0); expect_inv("R5", 1);

    // R5 + R7: pulses do not restart the timer with link test off
    fail = 1;
    rep(111, 1, 0, 0, 0, 1); expect_inv("R5", 1);
    step(1, 0, 0, 0, 1);     expect_inv("R5", 0);

    // R7 restart by activity, then expiry at 112th idle tick
    req = "R7";
    rep(4, 0, 0, 0, 1, 0); expect_inv("R7", 1);
    en = 1;
    rep(111, 0, 0, 0, 0, 1); expect_inv("R7", 1);
    step(1, 0, 0, 0, 0);
    rep(111, 0, 0, 0, 0, 1); expect_inv("R7", 1);
    step(0, 0, 0, 0, 1);     expect_inv("R7", 0);
    check(evt == 1, "R8", "pol_evt_o on restore", int'(evt), 1);

    // R6 runs flushed on change
    req = "R6";
    fail = 0;
    rep(10, 0, 1, 0, 0, 0); rep(4, 0, 0, 0, 1, 0); expect_inv("R6", 1);
    rep(6, 0, 1, 0, 0, 0);  expect_inv("R6", 1);
    rep(10, 0, 1, 0, 0, 0); expect_inv("R6", 0);

    // R10 independence of runs
    req = "R10";
    rep(8, 0, 1, 0, 0, 0); step(0, 0, 1, 0, 0); step(0, 0, 0, 1, 0);
    rep(7, 0, 1, 0, 0, 0); expect_inv("R10", 0);
    step(0, 1, 0, 0, 0);   expect_inv("R10", 1);

    // R7: ticks outside link fail do not advance timer
    req = "R7";
    rep(150, 0, 0, 0, 0, 1); expect_inv("R7", 1);
    fail = 1;
    rep(111, 0, 0, 0, 0, 1); expect_inv("R7", 1);
    step(0, 0, 0, 0, 1);     expect_inv("R7", 0);
    fail = 0;
    rep(3, 0, 0, 0, 0, 0);

    finish_run();
  end
endmodule